// File: doc/BRIEF.md
# Accumulator Compare Flag Unit

This block carries out the condition-code half of a compare-by-subtraction for a 16-bit signal-processing datapath whose accumulators are 36 bits wide. Each accumulator has three fields: a 4-bit guard field (bits 35:32), a 16-bit high word (bits 31:16) and a 16-bit low word (bits 15:0). The block takes a destination operand, which is either an accumulator or a 16-bit data register, and a source operand, which is either a 16-bit register or an accumulator. It forms destination minus source and throws the difference away. The only architectural effect is the update of seven condition bits in a 16-bit status register, which the block holds in flops.

When the destination is an accumulator, a 16-bit source is moved into the high-word position with zeros below it and is sign-extended through the guard field. The compare then runs over all 36 bits. When the destination is a 16-bit register, the compare is 16 bits wide. If the source is an accumulator in that case, only its high word takes part. The limit flag is sticky: once set, compares never clear it, and only reset does.

Top module: `acc_cmp_flags`

## Requirements
- R1: While reset is asserted, and after it is released, the status output equals the parameter SR_RESET (default 0x0300). Reset is the only event that clears the limit bit.
- R2: With dst_is_acc=1 and src_is_acc=0, the source value is {4 copies of src16[15], src16, 16'h0000}. For example, src16=0x8000 against a zero accumulator gives a positive result.
- R3: On the 36-bit path, with status bit positions C=0, V=1, Z=2, N=3: C is the borrow out of bit 35, V is 36-bit two's-complement overflow, Z is set when all 36 result bits are zero, and N is result bit 35.
- R4: On the 36-bit path, E (bit 5) is set when result bits 35:31 are not all equal, and U (bit 4) is set when result bit 31 equals bit 30.
- R5: With dst_is_acc=0, dst16 is compared with src16 (src_is_acc=0) or with src_acc[31:16] (src_is_acc=1). In the second case src_acc[35:32] and src_acc[15:0] have no effect.
- R6: On the 16-bit path, C is the borrow out of bit 15, V is 16-bit signed overflow, N is bit 15, Z is set for a zero 16-bit result, U is set when bit 15 equals bit 14, and E is cleared.
- R7: L (bit 6) is ORed with the new V on every compare. Once set, it stays set across later compares that do not overflow.
- R8: A compare writes only status bits 6:0. Bits 15:7, including the interrupt-mask bits 9:8, keep their value.
- R9: When cmp_en=0, the status register holds its value whatever the operand inputs do. A compare with cmp_en=1 updates it on the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_en | input | 1 | Load enable: perform the compare this cycle |
| dst_is_acc | input | 1 | 1: destination is an accumulator; 0: destination is a 16-bit register |
| src_is_acc | input | 1 | 1: source is an accumulator; 0: source is a 16-bit register |
| dst_acc | input | 36 | Destination accumulator value |
| dst16 | input | 16 | Destination 16-bit register value |
| src_acc | input | 36 | Source accumulator value |
| src16 | input | 16 | Source 16-bit register value |
| sr_q | output | 16 | Status register |

## Verification
The bench targets three kinds of mistake.

- **Sign extension of a negative 16-bit source.** A missing extension makes 0 compared with 0x8000 come out negative instead of positive, with E clear.
- **Operand selection on the 16-bit path.** An accumulator source is given nonzero guard and low fields. A design that leaks either field loses Z on an equal high word.
- **Flag history.** A 36-bit overflow at the most positive value is followed by compares without overflow, so a non-sticky L drops. Bits 9:8 are watched on every compare.

A held-enable cycle with changed operands exposes a design that ignores cmp_en. Each of these faults changes a status value the bench compares against.

// File: rtl/acf_pkg.sv
package acf_pkg;

    localparam int unsigned BIT_C = 0;
    localparam int unsigned BIT_V = 1;
    localparam int unsigned BIT_Z = 2;
    localparam int unsigned BIT_N = 3;
    localparam int unsigned BIT_U = 4;
    localparam int unsigned BIT_E = 5;
    localparam int unsigned BIT_L = 6;
    localparam int unsigned CC_W  = 7;

    typedef struct packed {
        logic l;
        logic e;
        logic u;
        logic n;
        logic z;
        logic v;
        logic c;
    } cc_t;

endpackage

// File: rtl/acf_align.sv
module acf_align #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned EXT_W  = 4,
    localparam int unsigned ACC_W = EXT_W + 2 * WORD_W
) (
    input  logic              src_is_acc,
    input  logic [ACC_W-1:0]  dst_acc,
    input  logic [WORD_W-1:0] dst16,
    input  logic [ACC_W-1:0]  src_acc,
    input  logic [WORD_W-1:0] src16,
    output logic [ACC_W-1:0]  wide_d,
    output logic [ACC_W-1:0]  wide_s,
    output logic [WORD_W-1:0] narrow_d,
    output logic [WORD_W-1:0] narrow_s
);

    logic [ACC_W-1:0]  src16_wide;
    logic [WORD_W-1:0] src_acc_hi;

    // Short source: placed in the high word, zero low word, guard bits copy its sign.
    assign src16_wide = {{EXT_W{src16[WORD_W-1]}}, src16, {WORD_W{1'b0}}};
    assign src_acc_hi = src_acc[2*WORD_W-1 -: WORD_W];

    always_comb begin
        wide_d   = dst_acc;
        wide_s   = src_is_acc ? src_acc : src16_wide;
        narrow_d = dst16;
        narrow_s = src_is_acc ? src_acc_hi : src16;
    end

endmodule

// File: rtl/acf_subtract.sv
module acf_subtract #(
    parameter int unsigned W = 36
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] diff,
    output logic         borrow,
    output logic         ovf
);

    logic [W:0] full;

    always_comb begin
        full   = {1'b0, a} - {1'b0, b};
        diff   = full[W-1:0];
        borrow = full[W];
        ovf    = (a[W-1] != b[W-1]) && (diff[W-1] != a[W-1]);
    end

endmodule

// File: rtl/acf_flag_gen.sv
module acf_flag_gen
    import acf_pkg::*;
#(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned EXT_W  = 4,
    localparam int unsigned ACC_W = EXT_W + 2 * WORD_W,
    localparam int unsigned HI_MSB = 2 * WORD_W - 1
) (
    input  logic              dst_is_acc,
    input  logic [ACC_W-1:0]  wide_r,
    input  logic              wide_borrow,
    input  logic              wide_ovf,
    input  logic [WORD_W-1:0] narrow_r,
    input  logic              narrow_borrow,
    input  logic              narrow_ovf,
    output cc_t               cc
);

    logic [EXT_W:0] guard_and_sign;

    assign guard_and_sign = wide_r[ACC_W-1:HI_MSB];

    always_comb begin
        cc = '0;
        if (dst_is_acc) begin
            cc.c = wide_borrow;
            cc.v = wide_ovf;
            cc.z = (wide_r == '0);
            cc.n = wide_r[ACC_W-1];
            cc.e = !((guard_and_sign == '0) || (guard_and_sign == '1));
            cc.u = (wide_r[HI_MSB] == wide_r[HI_MSB-1]);
        end else begin
            cc.c = narrow_borrow;
            cc.v = narrow_ovf;
            cc.z = (narrow_r == '0);
            cc.n = narrow_r[WORD_W-1];
            cc.e = 1'b0;
            cc.u = (narrow_r[WORD_W-1] == narrow_r[WORD_W-2]);
        end
        // Limit is merged with history in the register stage.
        cc.l = cc.v;
    end

endmodule

// File: rtl/acc_cmp_flags.sv
module acc_cmp_flags
    import acf_pkg::*;
#(
    parameter int unsigned WORD_W   = 16,
    parameter int unsigned EXT_W    = 4,
    parameter logic [15:0] SR_RESET = 16'h0300,
    localparam int unsigned ACC_W   = EXT_W + 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_en,
    input  logic              dst_is_acc,
    input  logic              src_is_acc,
    input  logic [ACC_W-1:0]  dst_acc,
    input  logic [WORD_W-1:0] dst16,
    input  logic [ACC_W-1:0]  src_acc,
    input  logic [WORD_W-1:0] src16,
    output logic [WORD_W-1:0] sr_q
);

    typedef struct packed {
        logic [WORD_W-1:0] sr;
    } state_t;

    state_t state_d, state_q;

    logic [ACC_W-1:0]  wide_d, wide_s, wide_r;
    logic [WORD_W-1:0] narrow_d, narrow_s, narrow_r;
    logic              wide_borrow, wide_ovf, narrow_borrow, narrow_ovf;
    cc_t               cc_new;

    acf_align #(.WORD_W(WORD_W), .EXT_W(EXT_W)) u_align (
        .src_is_acc (src_is_acc),
        .dst_acc    (dst_acc),
        .dst16      (dst16),
        .src_acc    (src_acc),
        .src16      (src16),
        .wide_d     (wide_d),
        .wide_s     (wide_s),
        .narrow_d   (narrow_d),
        .narrow_s   (narrow_s)
    );

    acf_subtract #(.W(ACC_W)) u_sub_wide (
        .a      (wide_d),
        .b      (wide_s),
        .diff   (wide_r),
        .borrow (wide_borrow),
        .ovf    (wide_ovf)
    );

    acf_subtract #(.W(WORD_W)) u_sub_narrow (
        .a      (narrow_d),
        .b      (narrow_s),
        .diff   (narrow_r),
        .borrow (narrow_borrow),
        .ovf    (narrow_ovf)
    );

    acf_flag_gen #(.WORD_W(WORD_W), .EXT_W(EXT_W)) u_flags (
        .dst_is_acc    (dst_is_acc),
        .wide_r        (wide_r),
        .wide_borrow   (wide_borrow),
        .wide_ovf      (wide_ovf),
        .narrow_r      (narrow_r),
        .narrow_borrow (narrow_borrow),
        .narrow_ovf    (narrow_ovf),
        .cc            (cc_new)
    );

    always_comb begin
        state_d = state_q;
        if (cmp_en) begin
            state_d.sr[CC_W-1:0] = cc_new;
            state_d.sr[BIT_L]    = state_q.sr[BIT_L] | cc_new.v;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.sr <= SR_RESET[WORD_W-1:0];
        end else begin
            state_q <= state_d;
        end
    end

    assign sr_q = state_q.sr;

endmodule

// File: rtl/acc_cmp_flags_chk.sv
module acc_cmp_flags_chk #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned EXT_W  = 4,
    localparam int unsigned ACC_W = EXT_W + 2 * WORD_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmp_en,
    input logic              dst_is_acc,
    input logic              src_is_acc,
    input logic [ACC_W-1:0]  dst_acc,
    input logic [WORD_W-1:0] dst16,
    input logic [ACC_W-1:0]  src_acc,
    input logic [WORD_W-1:0] sr_q
);

    assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_en |=> $stable(sr_q));

    assert_upper_bits_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_en |=> (sr_q[WORD_W-1:7] == $past(sr_q[WORD_W-1:7])));

    assert_limit_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sr_q[6] |=> sr_q[6]);

    assert_narrow_e_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && !dst_is_acc) |=> !sr_q[5]);

    assert_equal_acc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && dst_is_acc && src_is_acc && (dst_acc == src_acc))
        |=> (sr_q[2] && !sr_q[1] && !sr_q[0] && !sr_q[3]));

    assert_narrow_hi_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && !dst_is_acc && src_is_acc && (dst16 == src_acc[2*WORD_W-1 -: WORD_W]))
        |=> sr_q[2]);

endmodule

bind acc_cmp_flags acc_cmp_flags_chk #(.WORD_W(WORD_W), .EXT_W(EXT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmp_en     (cmp_en),
    .dst_is_acc (dst_is_acc),
    .src_is_acc (src_is_acc),
    .dst_acc    (dst_acc),
    .dst16      (dst16),
    .src_acc    (src_acc),
    .sr_q       (sr_q)
);

// File: tb/acc_cmp_flags_tb.sv
module acc_cmp_flags_tb;

    localparam int NV = 11;

    typedef struct packed {
        logic        en;
        logic        dacc;
        logic        sacc;
        logic [35:0] d36;
        logic [35:0] s36;
        logic [15:0] d16;
        logic [15:0] s16;
        logic [15:0] exp_sr;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b1, 1'b0, 36'h0_0020_0000, 36'h0,            16'h0000, 16'h0024, 16'h0319},
        '{1'b1, 1'b1, 1'b0, 36'h0_1234_0000, 36'h0,            16'h0000, 16'h1234, 16'h0314},
        '{1'b1, 1'b1, 1'b1, 36'h0_0000_0005, 36'h0_0000_0003,  16'h0000, 16'h0000, 16'h0310},
        '{1'b1, 1'b1, 1'b1, 36'h7_FFFF_FFFF, 36'hF_FFFF_FFFF,  16'h0000, 16'h0000, 16'h037B},
        '{1'b1, 1'b1, 1'b1, 36'h0_0000_0005, 36'h0_0000_0003,  16'h0000, 16'h0000, 16'h0350},
        '{1'b1, 1'b0, 1'b0, 36'h0,           36'h0,            16'h0005, 16'h0007, 16'h0359},
        '{1'b1, 1'b0, 1'b1, 36'h0,           36'hA_1234_FFFF,  16'h1234, 16'h0000, 16'h0354},
        '{1'b1, 1'b0, 1'b0, 36'h0,           36'h0,            16'h8000, 16'h0001, 16'h0342},
        '{1'b1, 1'b1, 1'b0, 36'h1_0000_0000, 36'h0,            16'h0000, 16'h0000, 16'h0370},
        '{1'b1, 1'b1, 1'b0, 36'h0,           36'h0,            16'h0000, 16'h8000, 16'h0361},
        '{1'b0, 1'b1, 1'b1, 36'h0,           36'h5_5555_5555,  16'h0000, 16'h0000, 16'h0361}
    };

    localparam string TAGS [NV] = '{
        "R2 example", "R3 equal", "R3 acc-acc", "R3 R4 overflow", "R7 sticky",
        "R6 narrow", "R5 hi word", "R6 narrow ovf", "R4 E set", "R2 sign ext",
        "R9 hold"
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_en = 1'b0;
    logic        dst_is_acc = 1'b0;
    logic        src_is_acc = 1'b0;
    logic [35:0] dst_acc = '0;
    logic [15:0] dst16 = '0;
    logic [35:0] src_acc = '0;
    logic [15:0] src16 = '0;
    logic [15:0] sr_q;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    acc_cmp_flags u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmp_en     (cmp_en),
        .dst_is_acc (dst_is_acc),
        .src_is_acc (src_is_acc),
        .dst_acc    (dst_acc),
        .dst16      (dst16),
        .src_acc    (src_acc),
        .src16      (src16),
        .sr_q       (sr_q)
    );

    task automatic check(input string tag, input logic [15:0] exp);
        n_chk++;
        if (sr_q !== exp) begin
            n_bad++;
            $display("FAIL %s: sr_q=%h expected=%h", tag, sr_q, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 in reset", 16'h0300);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", 16'h0300);

        for (int i = 0; i < NV; i++) begin
            cmp_en     = VECS[i].en;
            dst_is_acc = VECS[i].dacc;
            src_is_acc = VECS[i].sacc;
            dst_acc    = VECS[i].d36;
            src_acc    = VECS[i].s36;
            dst16      = VECS[i].d16;
            src16      = VECS[i].s16;
            @(negedge clk);
            check(TAGS[i], VECS[i].exp_sr);
        end

        // R8: mask bits 9:8 survived every compare above (all expected values carry 0x03xx).
        n_chk++;
        if (sr_q[15:7] !== 9'h006) begin
            n_bad++;
            $display("FAIL R8: sr_q[15:7]=%h expected=%h", sr_q[15:7], 9'h006);
        end

        // R1: reset clears the sticky limit bit.
        cmp_en = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset clears L", 16'h0300);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: sr_q=%h expected=completion", sr_q);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule